// File: doc/BRIEF.md
# Two-Level Nanocoded Control Sequencer

This block is the control store of a microcoded processor, split across two levels. A micro program counter addresses a narrow micro-store of 17-bit microwords. Each microword is one of two kinds. A branch word may redirect the micro program counter. A nano word points into a shared store of 68-bit nanowords, and the selected nanowort is expanded into 196 datapath control lines. Many microwords can name the same nanoword, so a control pattern that recurs across routines is stored only once.

Surrounding logic starts a routine by presenting an entry address with a load strobe. It steers conditional branches with a single condition flag. Each cycle it takes the control vector while the valid strobe is high. Both stores are filled from synthesizable tables that are computed from the address. A bench can therefore predict every word.

Top module: `nano_seq`

## Requirements
- R1: While `rst` is high, `valid_o` is 0 and `ctl_o` is all zero. The first clock edge with `rst` high sets `upc_o` to 0. Reset takes priority over the load strobe.
- R2: Microword format. Bit 16 is the kind flag: 1 means branch, 0 means nano pointer. In a branch word, bit 10 means unconditional and bits [9:0] hold the target. In a nano word, bits [8:0] hold the nanoword address. All other bits are zero.
- R3: When the current word is a branch and either `cond_i` or its unconditional bit is 1, `upc_o` takes the target at the next edge. During that cycle `valid_o` is 0 and `ctl_o` is zero.
- R4: When the current word is a branch that is not taken, `upc_o` advances by one at the next edge.
- R5: When the current word is a nano pointer, `valid_o` is 1 and `ctl_o` carries the expanded nanoword in that same cycle. `upc_o` advances by one at the next edge.
- R6: When `load_i` is high at an edge (and `rst` is low), `upc_o` takes `start_addr_i`. This overrides both increment and branch.
- R7: Expansion of nanoword `w` into `c`:
  - `c[3:0] = w[3:0]`.
  - For j in 0..15, `c[4+8j+v] = (w[4+3j+:3] == v)`.
  - For k in 0..3, `c[132+16k+v] = (w[52+4k+:4] == v)`.
- R8: Micro-store contents at address `a`:
  - If `a[2:0]` is 7, the word is a branch with unconditional bit `a[3]` and target `(a+17) mod 1024`.
  - Otherwise the word is a nano pointer to `a[5:0]`.
  - As a result, addresses that agree in their low six bits share a nanoword.
- R9: Nano-store contents at address `n`: each 17-bit chunk k (0..3, chunk k occupying bits [17k+16:17k]) equals `{n[8:0], n[7:0] ^ (8'h5A + k)}`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_addr_i | input | 10 | Routine entry address |
| load_i | input | 1 | Loads `start_addr_i` into the micro PC at the next edge |
| cond_i | input | 1 | Condition flag for branch words |
| ctl_o | output | 196 | Decoded control vector |
| upc_o | output | 10 | Current micro program counter |
| valid_o | output | 1 | Control vector is meaningful this cycle |

## Verification
The bench builds the block with its default widths: 17-bit microwords, 10-bit branch targets, 9-bit nano pointers, 68-bit nanowords and 196 control lines. This makes all 1024 micro addresses and both word kinds reachable through the load strobe alone. With these defaults, the bench can exercise taken and untaken conditional branches and unconditional branches, including one from the top micro address. It can also show two micro addresses sharing one nanoword, and decode every expansion field type against its own model of the tables.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    localparam int UW_W        = 17;
    localparam int TGT_W       = 10;
    localparam int PTR_W       = 9;
    localparam int NW_W        = 68;
    localparam int TYPE_BIT    = UW_W - 1;
    localparam int UNCOND_BIT  = TGT_W;

    // expansion layout: direct bits, 3-bit fields (one-hot 8), 4-bit fields (one-hot 16)
    localparam int N_DIRECT    = 4;
    localparam int N_F3        = 16;
    localparam int N_F4        = 4;
    localparam int F3_IN       = N_DIRECT;
    localparam int F4_IN       = F3_IN + 3 * N_F3;
    localparam int F3_OUT      = N_DIRECT;
    localparam int F4_OUT      = F3_OUT + 8 * N_F3;
    localparam int CTL_W       = F4_OUT + 16 * N_F4;
    localparam int USED_NW     = F4_IN + 4 * N_F4;

    localparam int UROM_D      = 1 << TGT_W;
    localparam int NROM_D      = 1 << PTR_W;
    localparam int SHARE_BITS  = 6;
    localparam int BR_SLOT     = 7;
    localparam int BR_STRIDE   = 17;
    localparam int CHUNK_W     = PTR_W + 8;
    localparam int NW_CHUNKS   = NW_W / CHUNK_W;

    typedef logic [UW_W-1:0]  uword_t;
    typedef logic [NW_W-1:0]  nword_t;
    typedef logic [TGT_W-1:0] uaddr_t;
    typedef logic [PTR_W-1:0] naddr_t;

    typedef enum logic { UW_NANO = 1'b0, UW_JUMP = 1'b1 } uw_kind_e;

    typedef struct packed {
        uw_kind_e kind;
        logic     uncond;
        uaddr_t   target;
        naddr_t   nptr;
    } uw_dec_t;

    function automatic uword_t ucode_word(input uaddr_t a);
        uword_t w;
        w = '0;
        if (a[2:0] == 3'(BR_SLOT)) begin
            w[TYPE_BIT]    = 1'b1;
            w[UNCOND_BIT]  = a[3];
            w[TGT_W-1:0]   = a + TGT_W'(BR_STRIDE);
        end else begin
            w[PTR_W-1:0]   = PTR_W'(a[SHARE_BITS-1:0]);
        end
        return w;
    endfunction

    function automatic nword_t nano_word(input naddr_t n);
        nword_t w;
        w = '0;
        for (int k = 0; k < NW_CHUNKS; k++)
            w[CHUNK_W*k +: CHUNK_W] = {n, n[7:0] ^ (8'h5A + 8'(k))};
        return w;
    endfunction

    function automatic uw_dec_t uw_decode(input uword_t w);
        uw_dec_t d;
        d.kind   = uw_kind_e'(w[TYPE_BIT]);
        d.uncond = w[UNCOND_BIT];
        d.target = w[TGT_W-1:0];
        d.nptr   = w[PTR_W-1:0];
        return d;
    endfunction

endpackage

// File: rtl/nseq_urom.sv
module nseq_urom
    import nseq_pkg::*;
(
    input  uaddr_t addr_i,
    output uword_t word_o
);
    uword_t mem [UROM_D];

    for (genvar i = 0; i < UROM_D; i++) begin : g_fill
        assign mem[i] = ucode_word(TGT_W'(i));
    end

    assign word_o = mem[addr_i];
endmodule

// File: rtl/nseq_nrom.sv
module nseq_nrom
    import nseq_pkg::*;
(
    input  naddr_t addr_i,
    output nword_t word_o
);
    nword_t mem [NROM_D];

    for (genvar i = 0; i < NROM_D; i++) begin : g_fill
        assign mem[i] = nano_word(PTR_W'(i));
    end

    assign word_o = mem[addr_i];
endmodule

// File: rtl/nseq_next.sv
module nseq_next
    import nseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  uaddr_t  start_i,
    input  logic    cond_i,
    input  uw_dec_t dec_i,
    output uaddr_t  upc_o
);
    uaddr_t upc_q, upc_d;
    logic   take;

    always_comb begin
        take = (dec_i.kind == UW_JUMP) && (cond_i || dec_i.uncond);
        if (load_i)    upc_d = start_i;
        else if (take) upc_d = dec_i.target;
        else           upc_d = upc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) upc_q <= '0;
        else     upc_q <= upc_d;
    end

    assign upc_o = upc_q;

    // R5
    nano_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && dec_i.kind == UW_NANO) |=> upc_q == $past(upc_q) + 1'b1);

    // R4
    untaken_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && dec_i.kind == UW_JUMP && !cond_i && !dec_i.uncond)
        |=> upc_q == $past(upc_q) + 1'b1);

    // R3
    taken_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && dec_i.kind == UW_JUMP && (cond_i || dec_i.uncond))
        |=> upc_q == $past(dec_i.target));
endmodule

// File: rtl/nseq_expand.sv
module nseq_expand
    import nseq_pkg::*;
(
    input  logic             en_i,
    input  nword_t           nw_i,
    output logic [CTL_W-1:0] ctl_o
);
    logic [CTL_W-1:0] raw;

    assign raw[N_DIRECT-1:0] = nw_i[N_DIRECT-1:0];

    for (genvar j = 0; j < N_F3; j++) begin : g_f3
        logic [2:0] sel;
        assign sel = nw_i[F3_IN + 3*j +: 3];
        assign raw[F3_OUT + 8*j +: 8] = 8'd1 << sel;
    end

    for (genvar k = 0; k < N_F4; k++) begin : g_f4
        logic [3:0] sel;
        assign sel = nw_i[F4_IN + 4*k +: 4];
        assign raw[F4_OUT + 16*k +: 16] = 16'd1 << sel;
    end

    logic unused_hi;
    if (USED_NW < NW_W) begin : g_spare
        assign unused_hi = ^nw_i[NW_W-1:USED_NW];
    end else begin : g_nospare
        assign unused_hi = 1'b0;
    end

    assign ctl_o = en_i ? raw : '0;
endmodule

// File: rtl/nano_seq.sv
module nano_seq
    import nseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [TGT_W-1:0] start_addr_i,
    input  logic             load_i,
    input  logic             cond_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic [TGT_W-1:0] upc_o,
    output logic             valid_o
);
    uword_t  uw;
    uw_dec_t dec;
    nword_t  nw;

    nseq_urom u_urom (.addr_i(upc_o), .word_o(uw));

    assign dec = uw_decode(uw);

    nseq_nrom u_nrom (.addr_i(dec.nptr), .word_o(nw));

    nseq_next u_next (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .start_i (start_addr_i),
        .cond_i  (cond_i),
        .dec_i   (dec),
        .upc_o   (upc_o)
    );

    assign valid_o = !rst && (dec.kind == UW_NANO);

    nseq_expand u_exp (.en_i(valid_o), .nw_i(nw), .ctl_o(ctl_o));

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> upc_o == '0);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |-> (!valid_o && ctl_o == '0));

    // R6
    load_override_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> upc_o == $past(start_addr_i));

    // R3
    idle_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ctl_o == '0);

    // R5
    live_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ctl_o != '0);

    // R2
    nano_resv_chk: assert property (@(posedge clk) disable iff (rst)
        !uw[TYPE_BIT] |-> uw[UW_W-2:PTR_W] == '0);

    // R2
    jump_resv_chk: assert property (@(posedge clk) disable iff (rst)
        uw[TYPE_BIT] |-> uw[UW_W-2:TGT_W+1] == '0);
endmodule

// File: tb/tb_nano_seq.sv
module tb_nano_seq;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [9:0]   start_addr = '0;
    logic         load = 1'b0;
    logic         cond = 1'b0;
    logic [195:0] ctl;
    logic [9:0]   upc;
    logic         valid;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    nano_seq dut (
        .clk          (clk),
        .rst          (rst),
        .start_addr_i (start_addr),
        .load_i       (load),
        .cond_i       (cond),
        .ctl_o        (ctl),
        .upc_o        (upc),
        .valid_o      (valid)
    );

    // reference model built from R7, R8, R9
    function automatic logic [67:0] m_nword(input logic [8:0] n);
        logic [67:0] w;
        for (int k = 0; k < 4; k++) w[17*k +: 17] = {n, n[7:0] ^ (8'h5A + 8'(k))};
        return w;
    endfunction

    function automatic logic [195:0] m_expand(input logic [67:0] w);
        logic [195:0] c;
        c = '0;
        for (int i = 0; i < 4; i++)  c[i] = w[i];
        for (int j = 0; j < 16; j++) c[4 + 8*j + int'(w[4 + 3*j +: 3])] = 1'b1;
        for (int k = 0; k < 4; k++)  c[132 + 16*k + int'(w[52 + 4*k +: 4])] = 1'b1;
        return c;
    endfunction

    function automatic logic m_valid(input logic [9:0] a);
        return a[2:0] != 3'd7;
    endfunction

    function automatic logic [195:0] m_ctl(input logic [9:0] a);
        return m_valid(a) ? m_expand(m_nword({3'b000, a[5:0]})) : '0;
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk_upc(input string req, input logic [9:0] exp);
        total++;
        if (upc !== exp) begin
            fails++;
            $display("FAIL %s: upc=%0d expected %0d", req, upc, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [9:0] a);
        total++;
        if (valid !== m_valid(a) || ctl !== m_ctl(a)) begin
            fails++;
            $display("FAIL %s: addr %0d valid=%0b ctl=%h expected valid=%0b ctl=%h",
                     req, a, valid, ctl, m_valid(a), m_ctl(a));
        end
    endtask

    task automatic do_load(input logic [9:0] a);
        start_addr = a;
        load = 1'b1;
        tick();
        load = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        total++;
        if (upc !== 10'd0 || valid !== 1'b0 || ctl !== '0) begin
            fails++;
            $display("FAIL R1: upc=%0d valid=%0b ctl=%h expected 0/0/0", upc, valid, ctl);
        end
        rst = 1'b0;
        #1;
        chk_out("R5 R7 R9 first word", 10'd0);
    endtask

    task automatic t_sequence();
        cond = 1'b0;
        for (int i = 1; i <= 7; i++) begin
            tick();
            chk_upc("R5 increment", 10'(i));
        end
        chk_out("R3 branch word quiet", 10'd7);
        tick();
        chk_upc("R4 untaken branch", 10'd8);
        chk_out("R5 after untaken", 10'd8);
    endtask

    task automatic t_cond_jump();
        do_load(10'd39);
        chk_upc("R6 load", 10'd39);
        cond = 1'b1;
        tick();
        cond = 1'b0;
        chk_upc("R3 conditional taken", 10'd56);
        chk_out("R5 at target", 10'd56);
    endtask

    task automatic t_uncond_jump();
        // R2 unconditional bit 10 set at address 15
        do_load(10'd15);
        cond = 1'b0;
        tick();
        chk_upc("R3 unconditional taken", 10'd32);
    endtask

    task automatic t_top_jump();
        do_load(10'd1022);
        tick();
        chk_upc("R5 increment to top", 10'd1023);
        tick();
        chk_upc("R3 branch from top wraps", 10'd16);
    endtask

    task automatic t_load_over_jump();
        do_load(10'd15);
        start_addr = 10'd300;
        load = 1'b1;
        tick();
        load = 1'b0;
        chk_upc("R6 load beats branch", 10'd300);
    endtask

    task automatic t_share();
        logic [195:0] first;
        do_load(10'd5);
        first = ctl;
        chk_out("R8 shared pointer low", 10'd5);
        do_load(10'd69);
        chk_out("R8 shared pointer high", 10'd69);
        total++;
        if (ctl !== first) begin
            fails++;
            $display("FAIL R9: shared ctl=%h expected %h", ctl, first);
        end
    endtask

    task automatic t_sweep();
        for (int a = 3; a < 1024; a += 41) begin
            do_load(10'(a));
            chk_out("R7 R8 sweep", 10'(a));
        end
    endtask

    task automatic t_reset_over_load();
        start_addr = 10'd500;
        load = 1'b1;
        rst = 1'b1;
        tick();
        chk_upc("R1 reset beats load", 10'd0);
        load = 1'b0;
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_sequence();
        t_cond_jump();
        t_uncond_jump();
        t_top_jump();
        t_load_over_jump();
        t_share();
        t_sweep();
        t_reset_over_load();
        summary();
        $finish;
    end
endmodule